// File: doc/BRIEF.md
# I/O Transfer Instruction Decoder

This block sits beside an accumulator machine's execute stage and handles the input/output transfer class of 12-bit instructions. When `exec` is high and the instruction's top three bits are `110`, the block splits the word into a 6-bit device code and a 3-bit function field. It then either acts on the processor's own interrupt-enable flag (device 0) or drives a small set of simple peripherals, each with a ready flag, a read-data bus and a start pulse.

For the simple peripherals, the three function bits combine within one instruction in a fixed order. First the ready test for a skip, then the accumulator clear, then the word transfer. Input devices OR their data into the accumulator value left by the clear step. Output devices receive that same value. A transfer also clears the device's ready flag and pulses its start line. The accumulator result and the skip decision are combinational in the instruction cycle. Ready flags, the interrupt-enable flag, the start pulses and the output data are registered at the clock edge that ends the cycle.

Top module: `iot_decoder`

## Requirements
- R1: Only an instruction with `exec` high and `instr[11:9]` = `110` has any effect. Any other word leaves `ac_out` equal to `ac_in`, keeps `skip` low, and changes no flag.
- R2: With device code `instr[8:3]` = 0, the octal word 6001 sets `int_en` at the next edge and 6002 clears it. Device 0 never pulses `dev_start`, never changes a ready flag and never alters the accumulator.
- R3: All ready flags and `int_en` are 0 after reset. A ready flag is set at the edge where its `dev_ready_set` bit is high, and it holds until a transfer clears it.
- R4: Function bit `instr[0]` asserts `skip` in the same cycle when the selected device's ready flag is 1. The test uses the flag value from before this instruction.
- R5: Function bit `instr[1]` forces the accumulator to 0 before any transfer.
- R6: Function bit `instr[2]` on an input device makes `ac_out` the accumulator after the clear step ORed with that device's read data. Peripheral codes 1 and 3 are inputs by default.
- R7: Function bit `instr[2]` on an output device loads `dev_wr_data` at the edge with the accumulator after the clear step. `ac_out` shows the same value. Codes 2 and 4 are outputs by default, and their read data is never used.
- R8: A transfer gives the selected device a one-cycle `dev_start` pulse after the edge and clears its ready flag at that edge. A `dev_ready_set` on the same edge takes priority and leaves the flag set.
- R9: In one instruction with all three function bits set, the skip is decided on the old ready flag, the clear comes before the transfer, and the flag is 0 afterwards.
- R10: Device codes above the number of peripherals produce no skip, no start pulse, no flag change and an unchanged accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec | input | 1 | Instruction in `instr` is executing this cycle |
| instr | input | 12 | Instruction word |
| ac_in | input | DW | Accumulator value before the instruction |
| ac_out | output | DW | Accumulator value after the instruction |
| skip | output | 1 | Skip the next instruction |
| int_en | output | 1 | Interrupt enable flag |
| dev_ready_set | input | NDEV | Per-device strobe that sets the ready flag |
| dev_rd_data | input | NDEV*DW | Per-device read data, device code k at slice k-1 |
| ready | output | NDEV | Per-device ready flags |
| dev_start | output | NDEV | One-cycle start pulse per device |
| dev_wr_data | output | DW | Word sent to an output device |

## Verification
The skip test and the transfer-side ready clear can act in the same cycle. An instruction with all three function bits set is issued to a ready input device. The bench expects `skip` high and `ac_out` equal to the device data alone while the instruction is held. It expects the flag to be low after the edge, and a second identical instruction must not skip. A device strobe arriving on the same edge as a transfer's clear is also provoked, and the flag must stay set.

// File: rtl/iot_decoder.sv
module iot_decoder #(
  parameter int DW = 12,
  parameter int NDEV = 4,
  parameter logic [NDEV-1:0] IN_DEVS = 'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec,
  input  logic [11:0]       instr,
  input  logic [DW-1:0]     ac_in,
  output logic [DW-1:0]     ac_out,
  output logic              skip,
  output logic              int_en,
  input  logic [NDEV-1:0]   dev_ready_set,
  input  logic [NDEV*DW-1:0] dev_rd_data,
  output logic [NDEV-1:0]   ready,
  output logic [NDEV-1:0]   dev_start,
  output logic [DW-1:0]     dev_wr_data
);
  localparam logic [2:0] IOT_OP = 3'b110;

  wire       is_iot = exec && (instr[11:9] == IOT_OP);
  wire [5:0] dev    = instr[8:3];
  wire [2:0] fn     = instr[2:0];

  logic [NDEV-1:0] sel;
  logic [DW-1:0]   rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NDEV; i++) begin
      sel[i] = is_iot && (dev == 6'(i + 1));
      if (sel[i]) rd_mux = rd_mux | dev_rd_data[i*DW +: DW];
    end
  end

  wire any_sel = |sel;
  wire sel_in  = |(sel & IN_DEVS);
  wire xfer    = any_sel && fn[2];

  wire [DW-1:0] ac_clr = (any_sel && fn[1]) ? '0 : ac_in;

  assign skip   = any_sel && fn[0] && |(sel & ready);
  assign ac_out = (xfer && sel_in) ? (ac_clr | rd_mux) : ac_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_en <= 1'b0;
    end else if (is_iot && dev == 6'd0) begin
      if (fn == 3'd1) int_en <= 1'b1;
      else if (fn == 3'd2) int_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_start   <= '0;
      dev_wr_data <= '0;
    end else begin
      dev_start <= sel & {NDEV{fn[2]}};
      if (xfer && !sel_in) dev_wr_data <= ac_clr;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NDEV; g++) begin : g_dev
      always_ff @(posedge clk) begin
        if (!rst_n) ready[g] <= 1'b0;
        else if (dev_ready_set[g]) ready[g] <= 1'b1;
        else if (sel[g] && fn[2]) ready[g] <= 1'b0;
      end

      // R3
      ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready[g]) |-> $past(dev_ready_set[g]));

      // R8
      start_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_start[g] && !$past(dev_ready_set[g])) |-> !ready[g]);
    end
  endgenerate

  // R8
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_start));

  // R2
  int_en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(int_en) |-> $past(exec && instr[11:3] == 9'o600));

  // R1
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec && instr[11:9] == IOT_OP) |-> (ac_out == ac_in && !skip));

  // R1
  idle_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec && instr[11:9] == IOT_OP) |=> dev_start == '0);
endmodule

// File: tb/iot_decoder_tb.sv
`timescale 1ns/1ps
module iot_decoder_tb;
  localparam int DW = 12;
  localparam int NDEV = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic exec = 0;
  logic [11:0] instr = '0;
  logic [DW-1:0] ac_in = '0;
  logic [DW-1:0] ac_out;
  logic skip, int_en;
  logic [NDEV-1:0] dev_ready_set = '0;
  logic [NDEV*DW-1:0] dev_rd_data;
  logic [NDEV-1:0] ready, dev_start;
  logic [DW-1:0] dev_wr_data;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  iot_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .exec(exec), .instr(instr), .ac_in(ac_in),
    .ac_out(ac_out), .skip(skip), .int_en(int_en),
    .dev_ready_set(dev_ready_set), .dev_rd_data(dev_rd_data),
    .ready(ready), .dev_start(dev_start), .dev_wr_data(dev_wr_data)
  );

  // device code 1 at slice 0 ... code 4 at slice 3
  assign dev_rd_data = {12'o7777, 12'o0102, 12'o7777, 12'o0070};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [11:0] w, input logic [DW-1:0] a,
                       input logic [NDEV-1:0] setm);
    @(negedge clk);
    exec = 1; instr = w; ac_in = a; dev_ready_set = setm;
    #2;
  endtask

  task automatic commit();
    @(posedge clk);
    #2;
    exec = 0; dev_ready_set = '0;
  endtask

  task automatic strobe(input int code);
    @(negedge clk);
    dev_ready_set[code-1] = 1'b1;
    @(negedge clk);
    dev_ready_set = '0;
    #2;
  endtask

  task automatic t_reset();
    check(ready == 0, "R3", "ready after reset", ready, 0);
    check(int_en == 0, "R3", "int_en after reset", int_en, 0);
    check(dev_start == 0 && !skip, "R3", "start/skip after reset", dev_start, 0);
  endtask

  task automatic t_int();
    issue(12'o6001, 12'o0123, '0);
    check(ac_out == 12'o0123, "R2", "ac on 6001", ac_out, 12'o0123);
    commit();
    check(int_en == 1, "R2", "int_en after 6001", int_en, 1);
    check(dev_start == 0, "R2", "no start on device 0", dev_start, 0);
    issue(12'o6002, 12'o0, '0);
    commit();
    check(int_en == 0, "R2", "int_en after 6002", int_en, 0);
  endtask

  task automatic t_opcode();
    strobe(3);
    issue(12'o5001, 12'o0777, '0);
    check(ac_out == 12'o0777 && !skip, "R1", "non-iot passthrough", ac_out, 12'o0777);
    commit();
    check(int_en == 0, "R1", "non-iot int_en", int_en, 0);
    issue(12'o7035, 12'o0444, '0);
    check(ac_out == 12'o0444 && !skip, "R1", "opcode 7 passthrough", ac_out, 12'o0444);
    commit();
    check(ready[2] == 1 && dev_start == 0, "R1", "opcode 7 ready kept", ready, 4'b0100);
  endtask

  task automatic t_skip();
    issue(12'o6011, 12'o0321, '0);
    check(!skip, "R4", "skip on not ready", skip, 0);
    commit();
    issue(12'o6031, 12'o0321, '0);
    check(skip, "R4", "skip on ready", skip, 1);
    check(ac_out == 12'o0321, "R4", "skip keeps ac", ac_out, 12'o0321);
    commit();
    check(ready[2] == 1, "R3", "ready held without transfer", ready[2], 1);
  endtask

  task automatic t_clear();
    issue(12'o6032, 12'o1234, '0);
    check(ac_out == 0, "R5", "clear ac", ac_out, 0);
    commit();
  endtask

  task automatic t_in();
    strobe(1);
    issue(12'o6014, 12'o1200, '0);
    check(ac_out == 12'o1270, "R6", "or data into ac", ac_out, 12'o1270);
    commit();
    check(dev_start == 4'b0001, "R8", "start pulse dev1", dev_start, 4'b0001);
    check(ready[0] == 0, "R8", "ready cleared dev1", ready[0], 0);
    @(posedge clk); #2;
    check(dev_start == 0, "R8", "start one cycle", dev_start, 0);
    issue(12'o6016, 12'o7777, '0);
    check(ac_out == 12'o0070, "R6", "clear then read", ac_out, 12'o0070);
    commit();
  endtask

  task automatic t_out();
    issue(12'o6044, 12'o4321, '0);
    check(ac_out == 12'o4321, "R7", "output keeps ac", ac_out, 12'o4321);
    commit();
    check(dev_wr_data == 12'o4321, "R7", "write data", dev_wr_data, 12'o4321);
    check(dev_start == 4'b1000, "R7", "start dev4", dev_start, 4'b1000);
    issue(12'o6046, 12'o4321, '0);
    check(ac_out == 0, "R7", "clear before output", ac_out, 0);
    commit();
    check(dev_wr_data == 0, "R7", "cleared write data", dev_wr_data, 0);
  endtask

  task automatic t_order();
    strobe(3);
    issue(12'o6037, 12'o5555, '0);
    check(skip, "R9", "skip on old ready", skip, 1);
    check(ac_out == 12'o0102, "R9", "clear then read", ac_out, 12'o0102);
    commit();
    check(ready[2] == 0, "R9", "ready cleared after", ready[2], 0);
    issue(12'o6037, 12'o0, '0);
    check(!skip, "R9", "no skip second time", skip, 0);
    commit();
  endtask

  task automatic t_race();
    issue(12'o6024, 12'o0017, 4'b0010);
    check(ac_out == 12'o0017, "R7", "output data not read", ac_out, 12'o0017);
    commit();
    check(ready[1] == 1, "R8", "set wins over clear", ready[1], 1);
    check(dev_start == 4'b0010, "R8", "start dev2", dev_start, 4'b0010);
  endtask

  task automatic t_unknown();
    strobe(4);
    issue(12'o6057, 12'o0606, '0);
    check(ac_out == 12'o0606 && !skip, "R10", "dev5 no effect", ac_out, 12'o0606);
    commit();
    check(dev_start == 0, "R10", "dev5 no start", dev_start, 0);
    issue(12'o6777, 12'o0606, '0);
    check(ac_out == 12'o0606 && !skip, "R10", "dev77 no effect", ac_out, 12'o0606);
    commit();
    check(ready == 4'b1010 && dev_start == 0, "R10", "flags kept", ready, 4'b1010);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_int();
    t_opcode();
    t_skip();
    t_clear();
    t_in();
    t_out();
    t_order();
    t_race();
    t_unknown();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule